// File: doc/BRIEF.md
# Shared-Bus Host Port Cycle Decoder

This block is the host-facing front end of a host port in which one bus carries both addresses and data. A host starts a cycle by asserting chip select and one of two data strobes. The block merges these into a single internal strobe. On the strobe's leading edge it captures a two-bit cycle code, the read/write direction, a halfword-select bit and the bus value. The cycle code routes the cycle to one of three targets: the control/status word, an address register, or the data path. The data path has two forms, one that moves the address forward after the access and one that leaves it where it is.

Data cycles become single-word requests on a simple memory-side handshake. Reads use the read address register and writes use the write address register. A control bit selects whether the two address registers are loaded together or one at a time. In 16-bit mode each 32-bit word takes two host cycles. Written halves are collected in a staging register, and read words are fetched once and handed out one half at a time. A ready output tells the host when the current cycle has finished. The control word also holds a host-interrupt bit and a CPU-interrupt bit, which the host and the local CPU can each set or clear.

Top module: `hpic_top`

## Requirements
- R1: A cycle starts only on the rising edge of the internal strobe, which is active when `cs_n` is low and `ds1_n` differs from `ds2_n`. Any other strobe state, such as `cs_n` high or both data strobes low, leaves `rdy` high and raises no memory request.
- R2: Code 2'b00 accesses the control word. Bit 1 is the CPU-interrupt flag, bit 2 is the host-interrupt flag and bit 9 is the split-address flag. Every other bit reads as zero.
- R3: Code 2'b10 accesses the address registers. When bit 9 is 0, a write loads both registers. When bit 9 is 1, a write loads the read address if `asel` is 1 and the write address if `asel` is 0. A read returns the read address.
- R4: Code 2'b11 performs one data access at the current address and leaves both addresses unchanged.
- R5: Code 2'b01 performs a data access and then adds 4 to the address that was used. When bit 9 is 0, both registers advance together. The memory address stays stable while a request is pending.
- R6: The cycle direction comes from `rnw`, sampled with the code: 1 means read, 0 means write. Data writes use the write address and data reads use the read address.
- R7: In 16-bit mode (`mode16`=1), `hw_sel`=0 marks the first halfword and `hw_sel`=1 marks the second. The first halfword is the low half and is only staged. The target is written when the second halfword arrives. A read fetches the word on the first halfword and returns bits 15:0, then returns bits 31:16 on the second halfword without a new memory request. Auto-increment takes effect after the second halfword.
- R8: `rdy` falls in the cycle after the strobe edge. It stays low for exactly one cycle on a register access. On a data access it stays low until the memory acknowledge has been taken. Read data sits on `hd_out` with `hd_oe` high only while `rdy` is high.
- R9: `hint_n` is the inverse of the host-interrupt flag. A CPU write sets the flag to `cpu_hint_val`. A host control write with bit 2 at 1 clears it, and a 0 in bit 2 has no effect. If both happen in the same cycle, the CPU value wins.
- R10: A host control write with bit 1 at 1 sets the CPU-interrupt flag, and a 0 in bit 1 has no effect. A CPU write with `cpu_irq_ack` at 1 clears the flag. If both happen in the same cycle, the set wins.
- R11: After reset, `rdy` is 1, `hint_n` is 1, and `cpu_irq`, `mem_req` and `hd_oe` are 0. Both addresses and all control flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode16 | input | 1 | 1 selects 16-bit halfword mode (change only while idle) |
| cs_n | input | 1 | Chip select, active low |
| ds1_n | input | 1 | Data strobe one |
| ds2_n | input | 1 | Data strobe two |
| rnw | input | 1 | Cycle direction, 1 = read |
| code | input | 2 | Cycle code selecting the target |
| hw_sel | input | 1 | Halfword select in 16-bit mode |
| asel | input | 1 | Address register choice in split mode, 1 = read address |
| hd_in | input | 32 | Host bus value driven by the host |
| hd_out | output | 32 | Host bus value returned on reads |
| hd_oe | output | 1 | Read data valid on `hd_out` |
| rdy | output | 1 | Ready, 1 = cycle finished or idle |
| hint_n | output | 1 | Host interrupt, active low |
| cpu_irq | output | 1 | CPU interrupt pending |
| cpu_we | input | 1 | CPU write to the interrupt flags |
| cpu_hint_val | input | 1 | New host-interrupt flag value on a CPU write |
| cpu_irq_ack | input | 1 | 1 clears the CPU-interrupt flag on a CPU write |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 32 | Read word, taken with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge of the request |

## Verification
A host control write and a CPU write to the interrupt flags can land in the same clock cycle. The bench starts a control-word write and raises the CPU write during the single cycle in which the decoder executes the register update. This is done twice. In the first run, the host sets the CPU-interrupt flag while the CPU acknowledges it, and the flag must remain pending. In the second run, the host clears the host-interrupt flag while the CPU sets it, and `hint_n` must end low.

// File: rtl/hpic_pkg.sv
package hpic_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    localparam int BIT_CPU_IRQ  = 1;
    localparam int BIT_HOST_IRQ = 2;
    localparam int BIT_SPLIT    = 9;

    typedef enum logic [1:0] {
        CODE_CTRL     = 2'b00,
        CODE_DATA_INC = 2'b01,
        CODE_ADDR     = 2'b10,
        CODE_DATA_FIX = 2'b11
    } cyc_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_MEM,
        ST_DONE
    } cyc_state_e;

    typedef struct packed {
        cyc_code_e         code;
        logic              rd;
        logic              hi;
        logic              asel;
        logic [WORD_W-1:0] din;
    } cyc_t;

    function automatic logic strobe_active(input logic cs_n, input logic d1_n, input logic d2_n);
        return !cs_n && (d1_n != d2_n);
    endfunction

    function automatic logic is_data(input cyc_code_e c);
        return (c == CODE_DATA_INC) || (c == CODE_DATA_FIX);
    endfunction

    // Two-bit register-select mask: bit 0 = read address, bit 1 = write address
    function automatic logic [1:0] addr_mask(input logic split, input logic pick_rd);
        if (!split) return 2'b11;
        return pick_rd ? 2'b01 : 2'b10;
    endfunction

endpackage

// File: rtl/hpic_strobe.sv
module hpic_strobe
    import hpic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic ds1_n,
    input  logic ds2_n,
    output logic stb,
    output logic stb_rise
);
    logic stb_q;

    assign stb      = strobe_active(cs_n, ds1_n, ds2_n);
    assign stb_rise = stb && !stb_q;

    always_ff @(posedge clk) begin
        if (rst) stb_q <= 1'b0;
        else     stb_q <= stb;
    end
endmodule

// File: rtl/hpic_ctl.sv
module hpic_ctl (
    input  logic clk,
    input  logic rst,
    input  logic host_we,
    input  logic host_irq_set,
    input  logic host_hint_clr,
    input  logic host_split,
    input  logic cpu_we,
    input  logic cpu_hint_val,
    input  logic cpu_irq_ack,
    output logic split,
    output logic host_irq,
    output logic cpu_irq_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            split        <= 1'b0;
            host_irq     <= 1'b0;
            cpu_irq_flag <= 1'b0;
        end else begin
            if (host_we) split <= host_split;
            // CPU write takes priority over a host clear
            if (cpu_we)                        host_irq <= cpu_hint_val;
            else if (host_we && host_hint_clr) host_irq <= 1'b0;
            // host set takes priority over a CPU acknowledge
            if (host_we && host_irq_set)       cpu_irq_flag <= 1'b1;
            else if (cpu_we && cpu_irq_ack)    cpu_irq_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/hpic_addr.sv
module hpic_addr #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    ld,
    input  logic [AW-1:0] ld_val,
    input  logic [1:0]    inc,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] wr_addr
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    for (genvar i = 0; i < 2; i++) begin : g_reg
        logic [AW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)         q <= '0;
            else if (ld[i])  q <= ld_val;
            else if (inc[i]) q <= q + STEP_V;
        end
    end

    assign rd_addr = g_reg[0].q;
    assign wr_addr = g_reg[1].q;
endmodule

// File: rtl/hpic_top.sv
module hpic_top
    import hpic_pkg::*;
#(
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode16,
    input  logic              cs_n,
    input  logic              ds1_n,
    input  logic              ds2_n,
    input  logic              rnw,
    input  logic [1:0]        code,
    input  logic              hw_sel,
    input  logic              asel,
    input  logic [31:0]       hd_in,
    output logic [31:0]       hd_out,
    output logic              hd_oe,
    output logic              rdy,
    output logic              hint_n,
    output logic              cpu_irq,
    input  logic              cpu_we,
    input  logic              cpu_hint_val,
    input  logic              cpu_irq_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack
);
    cyc_state_e        state;
    cyc_t              cyc;
    logic [HALF_W-1:0] stage;
    logic [WORD_W-1:0] rbuf;
    logic [WORD_W-1:0] wbuf;

    logic stb, stb_rise;
    logic split, host_irq;
    logic [AW-1:0] rd_addr, wr_addr;

    hpic_strobe u_stb (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ds1_n(ds1_n), .ds2_n(ds2_n),
        .stb(stb), .stb_rise(stb_rise)
    );

    // decode of the captured cycle
    logic              full_word, first_half, in_exec;
    logic [WORD_W-1:0] word_in;
    logic [WORD_W-1:0] ctl_word;
    logic              ctl_we, addr_we, inc_ev;
    logic [1:0]        ld_mask, inc_mask;

    assign full_word  = !mode16 || cyc.hi;
    assign first_half = !mode16 || !cyc.hi;
    assign in_exec    = (state == ST_EXEC);
    assign word_in    = mode16 ? {cyc.din[HALF_W-1:0], stage} : cyc.din;

    always_comb begin
        ctl_word               = '0;
        ctl_word[BIT_CPU_IRQ]  = cpu_irq;
        ctl_word[BIT_HOST_IRQ] = host_irq;
        ctl_word[BIT_SPLIT]    = split;
    end

    assign ctl_we  = in_exec && (cyc.code == CODE_CTRL) && !cyc.rd && full_word;
    assign addr_we = in_exec && (cyc.code == CODE_ADDR) && !cyc.rd && full_word;
    assign inc_ev  = (cyc.code == CODE_DATA_INC) &&
                     ((in_exec && cyc.rd && mode16 && cyc.hi) ||
                      ((state == ST_MEM) && mem_ack && (!cyc.rd || !mode16)));

    assign ld_mask  = addr_we ? addr_mask(split, cyc.asel) : 2'b00;
    assign inc_mask = inc_ev  ? addr_mask(split, cyc.rd)   : 2'b00;

    hpic_ctl u_ctl (
        .clk(clk), .rst(rst),
        .host_we(ctl_we),
        .host_irq_set(word_in[BIT_CPU_IRQ]),
        .host_hint_clr(word_in[BIT_HOST_IRQ]),
        .host_split(word_in[BIT_SPLIT]),
        .cpu_we(cpu_we), .cpu_hint_val(cpu_hint_val), .cpu_irq_ack(cpu_irq_ack),
        .split(split), .host_irq(host_irq), .cpu_irq_flag(cpu_irq)
    );

    hpic_addr #(.AW(AW), .STEP(WORD_BYTES)) u_addr (
        .clk(clk), .rst(rst),
        .ld(ld_mask), .ld_val(word_in[AW-1:0]), .inc(inc_mask),
        .rd_addr(rd_addr), .wr_addr(wr_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cyc   <= '0;
            stage <= '0;
            rbuf  <= '0;
            wbuf  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (stb_rise) begin
                        cyc.code <= cyc_code_e'(code);
                        cyc.rd   <= rnw;
                        cyc.hi   <= hw_sel;
                        cyc.asel <= asel;
                        cyc.din  <= hd_in;
                        state    <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (!cyc.rd && !full_word) stage <= cyc.din[HALF_W-1:0];
                    if (is_data(cyc.code)) begin
                        if (cyc.rd) begin
                            state <= first_half ? ST_MEM : ST_DONE;
                        end else if (full_word) begin
                            wbuf  <= word_in;
                            state <= ST_MEM;
                        end else begin
                            state <= ST_DONE;
                        end
                    end else begin
                        if (cyc.rd && first_half)
                            rbuf <= (cyc.code == CODE_CTRL) ? ctl_word : WORD_W'(rd_addr);
                        state <= ST_DONE;
                    end
                end
                ST_MEM: begin
                    if (mem_ack) begin
                        if (cyc.rd) rbuf <= mem_rdata;
                        state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (!stb) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rdy       = (state == ST_IDLE) || (state == ST_DONE);
    assign hd_oe     = (state == ST_DONE) && cyc.rd;
    assign hd_out    = !mode16 ? rbuf :
                       (cyc.hi ? {{HALF_W{1'b0}}, rbuf[WORD_W-1:HALF_W]}
                               : {{HALF_W{1'b0}}, rbuf[HALF_W-1:0]});
    assign hint_n    = !host_irq;
    assign mem_req   = (state == ST_MEM);
    assign mem_we    = !cyc.rd;
    assign mem_addr  = cyc.rd ? rd_addr : wr_addr;
    assign mem_wdata = wbuf;
endmodule

// File: rtl/hpic_chk.sv
module hpic_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          ds1_n,
    input logic          ds2_n,
    input logic          rdy,
    input logic          hd_oe,
    input logic          hint_n,
    input logic          cpu_irq,
    input logic          cpu_we,
    input logic          cpu_hint_val,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr
);
    logic stb_seen;
    assign stb_seen = !cs_n && (ds1_n != ds2_n);

    // R1
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy) |-> $past(stb_seen));

    // R8
    busy_mem_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !rdy);

    // R8
    oe_ready_chk: assert property (@(posedge clk) disable iff (rst)
        hd_oe |-> rdy);

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R9
    hint_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_hint_val) |=> !hint_n);

    // R9
    hint_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && !cpu_hint_val) |=> hint_n);

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_irq) |-> $past(!rdy));
endmodule

bind hpic_top hpic_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_hpic_top.sv
module sim_hpic_top;
    localparam int AW = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, mode16, cs_n, ds1_n, ds2_n, rnw, hw_sel, asel;
    logic [1:0] code;
    logic [31:0] hd_in, hd_out, mem_wdata, mem_rdata;
    logic hd_oe, rdy, hint_n, cpu_irq, cpu_we, cpu_hint_val, cpu_irq_ack;
    logic mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;

    hpic_top #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .mode16(mode16), .cs_n(cs_n), .ds1_n(ds1_n), .ds2_n(ds2_n),
        .rnw(rnw), .code(code), .hw_sel(hw_sel), .asel(asel), .hd_in(hd_in),
        .hd_out(hd_out), .hd_oe(hd_oe), .rdy(rdy), .hint_n(hint_n), .cpu_irq(cpu_irq),
        .cpu_we(cpu_we), .cpu_hint_val(cpu_hint_val), .cpu_irq_ack(cpu_irq_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int checks = 0;
    int errors = 0;
    int req_cnt = 0;
    bit finished = 0;

    // memory model: one-cycle registered acknowledge
    logic [31:0] mem [16];
    logic        ack_q;
    logic [31:0] rdata_q;
    assign mem_ack   = ack_q;
    assign mem_rdata = rdata_q;

    always @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= mem_req && !ack_q;
            if (mem_req && !ack_q) begin
                req_cnt <= req_cnt + 1;
                rdata_q <= mem[mem_addr[5:2]];
                if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard of expected read words
    typedef struct {
        logic [31:0] v;
        string       tag;
    } exp_t;
    exp_t sb[$];
    logic oe_prev = 1'b0;

    always @(negedge clk) begin
        if (hd_oe && !oe_prev) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8 unexpected read data actual=%h expected=none", hd_out);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, hd_out, e.v);
            end
        end
        oe_prev = hd_oe;
    end

    int last_nr;

    task automatic host_cycle(input logic [1:0] c, input logic r, input logic h, input logic a,
                              input logic [31:0] d, input logic col, input logic cv_h,
                              input logic cv_a);
        int nr;
        bit first;
        @(negedge clk);
        code = c; rnw = r; hw_sel = h; asel = a; hd_in = d;
        cs_n = 1'b0; ds1_n = 1'b0; ds2_n = 1'b1;
        nr = 0;
        first = 1;
        forever begin
            @(negedge clk);
            cpu_we = 1'b0;
            if (col && first) begin
                cpu_we = 1'b1; cpu_hint_val = cv_h; cpu_irq_ack = cv_a;
            end
            first = 0;
            if (!rdy) nr++;
            else break;
        end
        cpu_we = 1'b0;
        cs_n = 1'b1; ds1_n = 1'b1;
        @(negedge clk);
        last_nr = nr;
    endtask

    task automatic hwr(input logic [1:0] c, input logic h, input logic a, input logic [31:0] d);
        host_cycle(c, 1'b0, h, a, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic hrd(input logic [1:0] c, input logic h, input logic [31:0] exp, input string tag);
        exp_t e;
        e.v = exp; e.tag = tag;
        sb.push_back(e);
        host_cycle(c, 1'b1, h, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic cpu_write(input logic hv, input logic ack);
        @(negedge clk);
        cpu_we = 1'b1; cpu_hint_val = hv; cpu_irq_ack = ack;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            if (sb.size() != 0) begin
                checks++; errors++;
                $display("FAIL R8 missing reads actual=0 expected=%0d", sb.size());
            end
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int rc;
        for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 + i;
        rst = 1'b1; mode16 = 1'b0; cs_n = 1'b1; ds1_n = 1'b1; ds2_n = 1'b1;
        rnw = 1'b0; code = 2'b00; hw_sel = 1'b0; asel = 1'b0; hd_in = '0;
        cpu_we = 1'b0; cpu_hint_val = 1'b0; cpu_irq_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11 rdy", {31'b0, rdy}, 32'd1);
        chk("R11 hint_n", {31'b0, hint_n}, 32'd1);
        chk("R11 cpu_irq", {31'b0, cpu_irq}, 32'd0);
        chk("R11 mem_req/hd_oe", {30'b0, mem_req, hd_oe}, 32'd0);
        hrd(2'b10, 1'b0, 32'h0, "R11 address after reset");

        // R1 strobe states that must not start a cycle
        rc = req_cnt;
        cs_n = 1'b1; ds1_n = 1'b0; ds2_n = 1'b1; rnw = 1'b1; code = 2'b11;
        repeat (4) begin @(negedge clk); chk("R1 cs high rdy", {31'b0, rdy}, 32'd1); end
        cs_n = 1'b0; ds1_n = 1'b0; ds2_n = 1'b0;
        repeat (4) begin @(negedge clk); chk("R1 both strobes rdy", {31'b0, rdy}, 32'd1); end
        cs_n = 1'b1; ds1_n = 1'b1; ds2_n = 1'b1;
        @(negedge clk);
        chk("R1 no request", req_cnt, rc);

        // R3 linked address write, R8 register access timing
        hwr(2'b10, 1'b0, 1'b0, 32'h10);
        chk("R8 register access not-ready cycles", last_nr, 1);
        hrd(2'b10, 1'b0, 32'h10, "R3 address readback");

        // R4 R6 fixed data access
        hwr(2'b11, 1'b0, 1'b0, 32'hA5A5_0001);
        chk("R6 write reaches memory", mem[4], 32'hA5A5_0001);
        hrd(2'b11, 1'b0, 32'hA5A5_0001, "R4 fixed read");
        chk("R8 data read not-ready cycles", last_nr, 3);
        hrd(2'b10, 1'b0, 32'h10, "R4 address unchanged");

        // R5 auto-increment, linked mode
        hwr(2'b01, 1'b0, 1'b0, 32'hB0B0_000B);
        hwr(2'b01, 1'b0, 1'b0, 32'hC0C0_000C);
        chk("R5 inc write first", mem[4], 32'hB0B0_000B);
        chk("R5 inc write second", mem[5], 32'hC0C0_000C);
        hrd(2'b10, 1'b0, 32'h18, "R5 both moved after writes");
        hwr(2'b10, 1'b0, 1'b0, 32'h10);
        hrd(2'b01, 1'b0, 32'hB0B0_000B, "R5 inc read first");
        hrd(2'b01, 1'b0, 32'hC0C0_000C, "R5 inc read second");
        hrd(2'b10, 1'b0, 32'h18, "R5 read address advanced");

        // R2 R3 split addressing
        hwr(2'b00, 1'b0, 1'b0, 32'h0000_0200);
        hrd(2'b00, 1'b0, 32'h0000_0200, "R2 control readback");
        hwr(2'b10, 1'b0, 1'b1, 32'h20);
        hwr(2'b10, 1'b0, 1'b0, 32'h30);
        hwr(2'b11, 1'b0, 1'b0, 32'hD0D0_000D);
        chk("R3 write address used", mem[12], 32'hD0D0_000D);
        hrd(2'b10, 1'b0, 32'h20, "R3 read address separate");
        hrd(2'b01, 1'b0, 32'h1000_0008, "R6 read uses read address");
        hrd(2'b10, 1'b0, 32'h24, "R5 split read increment");
        hwr(2'b01, 1'b0, 1'b0, 32'hE0E0_000E);
        hwr(2'b11, 1'b0, 1'b0, 32'hF0F0_000F);
        chk("R5 split write inc first", mem[12], 32'hE0E0_000E);
        chk("R5 split write inc second", mem[13], 32'hF0F0_000F);
        hrd(2'b10, 1'b0, 32'h24, "R5 read address untouched by writes");

        // R10 CPU interrupt flag
        hwr(2'b00, 1'b0, 1'b0, 32'h0000_0202);
        chk("R10 host sets", {31'b0, cpu_irq}, 32'd1);
        hwr(2'b00, 1'b0, 1'b0, 32'h0000_0200);
        chk("R10 host zero no effect", {31'b0, cpu_irq}, 32'd1);
        hrd(2'b00, 1'b0, 32'h0000_0202, "R2 control shows cpu flag");
        cpu_write(1'b0, 1'b1);
        chk("R10 cpu clears", {31'b0, cpu_irq}, 32'd0);

        // R9 host interrupt flag
        cpu_write(1'b1, 1'b0);
        chk("R9 cpu sets", {31'b0, hint_n}, 32'd0);
        hwr(2'b00, 1'b0, 1'b0, 32'h0000_0200);
        chk("R9 host zero no effect", {31'b0, hint_n}, 32'd0);
        hrd(2'b00, 1'b0, 32'h0000_0204, "R2 control shows host flag");
        hwr(2'b00, 1'b0, 1'b0, 32'h0000_0204);
        chk("R9 host clears", {31'b0, hint_n}, 32'd1);

        // same-cycle collisions
        host_cycle(2'b00, 1'b0, 1'b0, 1'b0, 32'h0000_0202, 1'b1, 1'b0, 1'b1);
        chk("R10 host set beats cpu ack", {31'b0, cpu_irq}, 32'd1);
        host_cycle(2'b00, 1'b0, 1'b0, 1'b0, 32'h0000_0204, 1'b1, 1'b1, 1'b0);
        chk("R9 cpu set beats host clear", {31'b0, hint_n}, 32'd0);
        cpu_write(1'b0, 1'b1);
        chk("R9 R10 cleanup", {30'b0, hint_n, cpu_irq}, 32'd2);

        // R7 16-bit halfword mode
        hwr(2'b00, 1'b0, 1'b0, 32'h0);
        mode16 = 1'b1;
        hwr(2'b00, 1'b0, 1'b0, 32'h0002);
        chk("R7 control not written on first half", {31'b0, cpu_irq}, 32'd0);
        hwr(2'b00, 1'b1, 1'b0, 32'h0000);
        chk("R7 control written on second half", {31'b0, cpu_irq}, 32'd1);
        cpu_write(1'b0, 1'b1);
        hwr(2'b10, 1'b0, 1'b0, 32'h0008);
        hwr(2'b10, 1'b1, 1'b0, 32'h0000);
        hrd(2'b10, 1'b0, 32'h0008, "R7 address low half");
        hrd(2'b10, 1'b1, 32'h0000, "R7 address high half");
        hwr(2'b01, 1'b0, 1'b0, 32'h5678);
        chk("R7 memory untouched after first half", mem[2], 32'h1000_0002);
        hwr(2'b01, 1'b1, 1'b0, 32'h1234);
        chk("R7 assembled word", mem[2], 32'h1234_5678);
        hrd(2'b10, 1'b0, 32'h000C, "R5 R7 increment after pair");
        hwr(2'b10, 1'b0, 1'b0, 32'h0008);
        hwr(2'b10, 1'b1, 1'b0, 32'h0000);
        rc = req_cnt;
        hrd(2'b11, 1'b0, 32'h5678, "R7 read low half");
        hrd(2'b11, 1'b1, 32'h1234, "R7 read high half");
        chk("R7 one fetch per word", req_cnt - rc, 1);
        mode16 = 1'b0;

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule